// File: doc/BRIEF.md
# Two-Way Lockable Data Cache

This block sits between a 32-bit load/store port and a word-wide memory port that can stream a line as a burst. It stores lines of four 32-bit words in two ways per set, addressed physically. With the default 8 KB capacity the set index is address bits [11:4], the tag is bits [31:12] and bits [3:2] select the word. Loads and stores that hit complete in the cycle they are presented. A miss refills the whole line with a four-beat burst and completes one cycle after the last beat. A dirty victim is first written back as a four-beat burst.

Each access carries a two-bit attribute that picks its write policy. Code 2'b00 is copyback, code 2'b01 is writethrough, and codes 2'b10 and 2'b11 are cache-inhibited. A control port takes a line address and an opcode: 2'b01 locks the resident line, 2'b10 unlocks it and 2'b11 invalidates it. A locked line is never replaced. When both ways of a set are locked, a miss to that set goes to memory as a single uncached beat.

The CPU holds `req_valid` and its fields stable until `req_done` is high at a clock edge. The memory side holds `mem_req`, `mem_addr` and `mem_we` until `mem_ack`. Each acknowledged beat advances the burst by one word.

Top module: `lockable_dcache`

## Requirements
- R1: After reset no memory request and no completion are signalled, and every line is invalid and unlocked, so the first access to any address misses.
- R2: A load hit, or a copyback (attr 2'b00) store hit, raises `req_done` in the cycle it is presented with no memory traffic; a load returns the latest value stored to that word.
- R3: A cacheable miss issues four burst read beats (`mem_burst`=1, `mem_we`=0) at the line's word addresses in ascending order. Request and address are held until acknowledged, and `req_done` rises one cycle after the last beat's acknowledge (5 cycles after presentation with zero-wait memory).
- R4: With both ways valid and unlocked, a miss replaces the least recently used way of the set.
- R5: A line locked with op 2'b01 is never chosen as a victim. Control commands are accepted (`ctl_ack`=1) only in a cycle with no access pending.
- R6: When both ways of the set are locked, a miss is served by one single-beat memory read and allocates nothing.
- R7: A copyback store hit updates the line and marks it dirty without writing memory. A dirty victim is written back as four burst write beats before the refill reads start.
- R8: A writethrough (attr 2'b01) store hit updates the line and issues one single-beat memory write; `req_done` rises with that write's acknowledge.
- R9: A writethrough store miss issues one single-beat memory write and allocates no line.
- R10: An inhibited access (attr 2'b1x) uses one single memory beat and allocates nothing, even when the line is resident.
- R11: Invalidate (op 2'b11) clears the line's valid, dirty and lock state; dirty data is dropped with no write-back.
- R12: Unlock (op 2'b10) makes the line a replacement candidate again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access presented, held until done |
| req_write | input | 1 | 1 for store, 0 for load |
| req_attr | input | 2 | 00 copyback, 01 writethrough, 1x inhibited |
| req_addr | input | 32 | Byte address (word aligned) |
| req_wdata | input | 32 | Store data |
| req_done | output | 1 | Access completes at this edge |
| req_rdata | output | 32 | Load data, valid with req_done |
| ctl_valid | input | 1 | Control command presented |
| ctl_op | input | 2 | 01 lock, 10 unlock, 11 invalidate |
| ctl_addr | input | 32 | Address of the line to act on |
| ctl_ack | output | 1 | Command taken at this edge |
| mem_req | output | 1 | Memory beat requested |
| mem_we | output | 1 | Beat is a write |
| mem_burst | output | 1 | Beat belongs to a four-beat line burst |
| mem_addr | output | 32 | Word address of the current beat |
| mem_wdata | output | 32 | Write data of the current beat |
| mem_ack | input | 1 | Current beat accepted |
| mem_rdata | input | 32 | Read data of the current beat |

## Verification
Properties in the design check, on every cycle, that a pending memory beat keeps its address and direction until acknowledged, and that a locked line is never the target of a write-back or refill. They also check that a load completes one cycle after the last refill beat, and that a write-back is always followed directly by a refill. Only the scenarios can show replacement order under LRU, writethrough and inhibited traffic counts, the absence of allocation, and the loss of dirty data on invalidate. The bench compares load data against a flat model of architectural memory and counts memory beats by kind.

// File: rtl/lockable_dcache.sv
module lockable_dcache #(
  parameter int CACHE_BYTES = 8192,
  parameter int LINE_WORDS  = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [1:0]  req_attr,
  input  logic [31:0] req_addr,
  input  logic [31:0] req_wdata,
  output logic        req_done,
  output logic [31:0] req_rdata,
  input  logic        ctl_valid,
  input  logic [1:0]  ctl_op,
  input  logic [31:0] ctl_addr,
  output logic        ctl_ack,
  output logic        mem_req,
  output logic        mem_we,
  output logic        mem_burst,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata
);
  localparam int SETS = CACHE_BYTES / (8 * LINE_WORDS);
  localparam int BW   = $clog2(LINE_WORDS);
  localparam int OFF  = BW + 2;
  localparam int IW   = $clog2(SETS);
  localparam int TW   = 32 - IW - OFF;
  localparam logic [BW-1:0] LAST = BW'(LINE_WORDS - 1);

  typedef enum logic [1:0] {S_IDLE, S_WB, S_FILL, S_ONE} st_t;

  st_t            st_q;
  logic [BW-1:0]  beat_q;
  logic [IW-1:0]  f_idx_q;
  logic [TW-1:0]  f_tag_q;
  logic           f_way_q;

  logic [31:0]    dat_q [2][SETS][LINE_WORDS];
  logic [TW-1:0]  tag_q [2][SETS];
  logic [SETS-1:0] vld_q [2];
  logic [SETS-1:0] drt_q [2];
  logic [SETS-1:0] lck_q [2];
  logic [SETS-1:0] lru_q;

  wire [IW-1:0] idx  = req_addr[OFF +: IW];
  wire [TW-1:0] tg   = req_addr[31 -: TW];
  wire [BW-1:0] wsel = req_addr[2 +: BW];
  wire h0   = vld_q[0][idx] && (tag_q[0][idx] == tg);
  wire h1   = vld_q[1][idx] && (tag_q[1][idx] == tg);
  wire hit  = h0 || h1;
  wire hw   = h1;
  wire inh  = req_attr[1];
  wire wt   = (req_attr == 2'b01);
  wire lk0  = lck_q[0][idx];
  wire lk1  = lck_q[1][idx];
  wire look = (st_q == S_IDLE) && req_valid;

  wire vic = lk0 ? 1'b1 :
             lk1 ? 1'b0 :
             !vld_q[0][idx] ? 1'b0 :
             !vld_q[1][idx] ? 1'b1 : lru_q[idx];

  wire bypass = inh || (!hit && ((req_write && wt) || (lk0 && lk1)));
  wire hit_go = look && !inh && hit;
  wire fill_last = (st_q == S_FILL) && mem_ack && (beat_q == LAST);

  wire [IW-1:0] c_idx = ctl_addr[OFF +: IW];
  wire [TW-1:0] c_tg  = ctl_addr[31 -: TW];
  wire c_h0 = vld_q[0][c_idx] && (tag_q[0][c_idx] == c_tg);
  wire c_h1 = vld_q[1][c_idx] && (tag_q[1][c_idx] == c_tg);
  wire unused_addr_bits = ^{ctl_addr[OFF-1:0], req_addr[1:0]};

  assign ctl_ack   = ctl_valid && (st_q == S_IDLE) && !req_valid;
  assign req_done  = (hit_go && !(req_write && wt)) || ((st_q == S_ONE) && mem_ack);
  assign req_rdata = (st_q == S_ONE) ? mem_rdata : dat_q[hw][idx][wsel];
  assign mem_req   = (st_q != S_IDLE);
  assign mem_burst = (st_q == S_WB) || (st_q == S_FILL);
  assign mem_we    = (st_q == S_WB) || ((st_q == S_ONE) && req_write);
  assign mem_wdata = (st_q == S_WB) ? dat_q[f_way_q][f_idx_q][beat_q] : req_wdata;

  always_comb begin
    case (st_q)
      S_WB:    mem_addr = {tag_q[f_way_q][f_idx_q], f_idx_q, beat_q, 2'b00};
      S_FILL:  mem_addr = {f_tag_q, f_idx_q, beat_q, 2'b00};
      default: mem_addr = {req_addr[31:2], 2'b00};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      beat_q  <= '0;
      f_idx_q <= '0;
      f_tag_q <= '0;
      f_way_q <= 1'b0;
    end else begin
      case (st_q)
        S_IDLE: if (look) begin
          if (bypass || (hit && req_write && wt)) begin
            st_q <= S_ONE;
          end else if (!hit) begin
            f_idx_q <= idx;
            f_tag_q <= tg;
            f_way_q <= vic;
            beat_q  <= '0;
            st_q    <= (vld_q[vic][idx] && drt_q[vic][idx]) ? S_WB : S_FILL;
          end
        end
        S_WB: if (mem_ack) begin
          beat_q <= beat_q + BW'(1);
          if (beat_q == LAST) begin
            beat_q <= '0;
            st_q   <= S_FILL;
          end
        end
        S_FILL: if (mem_ack) begin
          beat_q <= beat_q + BW'(1);
          if (beat_q == LAST) st_q <= S_IDLE;
        end
        default: if (mem_ack) st_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q[0] <= '0;
      vld_q[1] <= '0;
      drt_q[0] <= '0;
      drt_q[1] <= '0;
      lck_q[0] <= '0;
      lck_q[1] <= '0;
      lru_q    <= '0;
    end else begin
      if (hit_go) begin
        lru_q[idx] <= ~hw;
        if (req_write && !wt) drt_q[hw][idx] <= 1'b1;
      end
      if (fill_last) begin
        vld_q[f_way_q][f_idx_q] <= 1'b1;
        drt_q[f_way_q][f_idx_q] <= 1'b0;
        lru_q[f_idx_q]          <= ~f_way_q;
      end
      if (ctl_ack && (c_h0 || c_h1)) begin
        case (ctl_op)
          2'b01: lck_q[c_h1][c_idx] <= 1'b1;
          2'b10: lck_q[c_h1][c_idx] <= 1'b0;
          2'b11: begin
            vld_q[c_h1][c_idx] <= 1'b0;
            drt_q[c_h1][c_idx] <= 1'b0;
            lck_q[c_h1][c_idx] <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (hit_go && req_write) dat_q[hw][idx][wsel] <= req_wdata;
    if ((st_q == S_FILL) && mem_ack) dat_q[f_way_q][f_idx_q][beat_q] <= mem_rdata;
    if (fill_last) tag_q[f_way_q][f_idx_q] <= f_tag_q;
  end

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !mem_req) else $error("reset quiet"); // R1
  AST_DONE_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n) req_done |-> req_valid) else $error("done without request"); // R2
  AST_BEAT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)) else $error("beat dropped"); // R3
  AST_FILL_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    fill_last && req_valid && !req_write |=> req_done || !req_valid) else $error("late completion"); // R3
  AST_LOCKED_SPARED: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_WB || st_q == S_FILL) |-> !lck_q[f_way_q][f_idx_q]) else $error("locked victim"); // R5
  AST_WB_THEN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_WB) && mem_ack && (beat_q == LAST) |=> (st_q == S_FILL) && mem_burst && !mem_we) else $error("refill order"); // R7
endmodule

// File: tb/lockable_dcache_tb.sv
module lockable_dcache_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] CB = 2'b00, WT = 2'b01, IN = 2'b10, IN3 = 2'b11;
  localparam logic [1:0] OP_LOCK = 2'b01, OP_UNLOCK = 2'b10, OP_INVAL = 2'b11;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [1:0] req_attr = '0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic req_done;
  logic [31:0] req_rdata;
  logic ctl_valid = 1'b0;
  logic [1:0] ctl_op = '0;
  logic [31:0] ctl_addr = '0;
  logic ctl_ack;
  logic mem_req, mem_we, mem_burst, mem_ack;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lockable_dcache u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_attr(req_attr),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_done(req_done), .req_rdata(req_rdata),
    .ctl_valid(ctl_valid), .ctl_op(ctl_op), .ctl_addr(ctl_addr), .ctl_ack(ctl_ack),
    .mem_req(mem_req), .mem_we(mem_we), .mem_burst(mem_burst), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int n_cmp = 0, n_bad = 0;
  int n_br = 0, n_bw = 0, n_sr = 0, n_sw = 0;
  int b0, b1, b2, b3;
  bit saw_br = 0, order_bad = 0;
  logic [31:0] mem_q [logic [31:0]];
  logic [31:0] shadow_q [logic [31:0]];
  logic [31:0] exp_q [$];
  string why_q [$];

  function automatic logic [31:0] init_val(input logic [31:0] a);
    return {~a[15:0], a[15:0]};
  endfunction
  function automatic logic [31:0] peek(input logic [31:0] a);
    if (mem_q.exists(a)) return mem_q[a];
    return init_val(a);
  endfunction
  function automatic logic [31:0] sh_get(input logic [31:0] a);
    if (shadow_q.exists(a)) return shadow_q[a];
    return init_val(a);
  endfunction

  task automatic chk(input bit ok, input string why, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", why, act, exp);
    end
  endtask

  assign mem_ack = mem_req;
  always @(posedge clk) begin
    if (rst_n && mem_req && mem_ack) begin
      if (mem_we) mem_q[mem_addr] = mem_wdata;
      if (mem_burst && mem_we) begin n_bw++; if (saw_br) order_bad = 1; end
      if (mem_burst && !mem_we) begin n_br++; saw_br = 1; end
      if (!mem_burst && mem_we) n_sw++;
      if (!mem_burst && !mem_we) n_sr++;
    end
  end
  always begin
    @(posedge clk);
    #2 mem_rdata = peek(mem_addr);
  end

  always @(negedge clk) begin : monitor
    logic [31:0] e;
    string w;
    if (rst_n && req_valid && req_done && !req_write) begin
      if (exp_q.size() == 0) chk(1'b0, "R2 unexpected response", req_rdata, 32'h0);
      else begin
        e = exp_q.pop_front();
        w = why_q.pop_front();
        chk(req_rdata === e, w, req_rdata, e);
      end
    end
  end

  task automatic acc(input bit wr, input logic [1:0] at, input logic [31:0] a,
                     input logic [31:0] wd, input int lat_exp, input string why);
    int lat;
    @(posedge clk); #1;
    req_valid = 1'b1; req_write = wr; req_attr = at; req_addr = a; req_wdata = wd;
    if (wr) shadow_q[a] = wd;
    else begin exp_q.push_back(sh_get(a)); why_q.push_back({why, " data"}); end
    lat = 0;
    @(negedge clk);
    while (!req_done) begin lat++; @(negedge clk); end
    chk(lat == lat_exp, {why, " latency"}, 32'(lat), 32'(lat_exp));
    @(posedge clk); #1 req_valid = 1'b0;
  endtask

  task automatic ctl(input logic [1:0] op, input logic [31:0] a, input string why);
    @(posedge clk); #1;
    ctl_valid = 1'b1; ctl_op = op; ctl_addr = a;
    @(negedge clk);
    chk(ctl_ack === 1'b1, why, {31'b0, ctl_ack}, 32'h1);
    @(posedge clk); #1 ctl_valid = 1'b0;
  endtask

  task automatic snap();
    b0 = n_br; b1 = n_bw; b2 = n_sr; b3 = n_sw;
  endtask
  task automatic traffic(input int br, input int bw, input int sr, input int sw, input string why);
    chk(n_br - b0 == br, {why, " burst reads"}, 32'(n_br - b0), 32'(br));
    chk(n_bw - b1 == bw, {why, " burst writes"}, 32'(n_bw - b1), 32'(bw));
    chk(n_sr - b2 == sr, {why, " single reads"}, 32'(n_sr - b2), 32'(sr));
    chk(n_sw - b3 == sw, {why, " single writes"}, 32'(n_sw - b3), 32'(sw));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R3 watchdog: actual hung expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : driver
    logic [31:0] A, B, C, D, E, F;
    A = 32'h0000_1040; B = 32'h0000_2040; C = 32'h0000_3040; D = 32'h0000_4040;
    E = 32'h0000_5080; F = 32'h0000_6100;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(mem_req === 1'b0, "R1 no request after reset", {31'b0, mem_req}, 32'h0);
    chk(req_done === 1'b0, "R1 no completion after reset", {31'b0, req_done}, 32'h0);

    snap(); acc(0, CB, A, 0, 5, "R1 R3 clean miss"); traffic(4, 0, 0, 0, "R3 refill burst");
    snap(); acc(0, CB, A + 4, 0, 0, "R2 load hit"); acc(0, CB, A + 12, 0, 0, "R2 load hit last word");
    traffic(0, 0, 0, 0, "R2 hit traffic");

    acc(0, CB, B, 0, 5, "R4 fill second way");
    acc(0, CB, A, 0, 0, "R4 touch first way");
    acc(0, CB, C, 0, 5, "R4 miss replaces LRU");
    snap(); acc(0, CB, A, 0, 0, "R4 recently used kept"); traffic(0, 0, 0, 0, "R4 kept");
    acc(0, CB, B, 0, 5, "R4 LRU line was evicted");

    ctl(OP_LOCK, A, "R5 lock accepted");
    acc(0, CB, C, 0, 5, "R5 fill beside lock");
    acc(0, CB, D, 0, 5, "R5 fill beside lock");
    acc(0, CB, B, 0, 5, "R5 fill beside lock");
    acc(0, CB, C, 0, 5, "R5 fill beside lock");
    snap(); acc(0, CB, A, 0, 0, "R5 locked line survives"); traffic(0, 0, 0, 0, "R5 locked");

    ctl(OP_LOCK, C, "R6 lock second way");
    snap(); acc(0, CB, D, 0, 1, "R6 uncached read"); traffic(0, 0, 1, 0, "R6 bypass");
    snap(); acc(0, CB, D, 0, 1, "R6 not allocated"); traffic(0, 0, 1, 0, "R6 repeat");

    ctl(OP_UNLOCK, C, "R12 unlock accepted");
    snap(); acc(0, CB, D, 0, 5, "R12 unlocked way refilled"); traffic(4, 0, 0, 0, "R12 refill");
    acc(0, CB, C, 0, 5, "R12 unlocked line evicted");

    snap(); acc(1, CB, A + 8, 32'hCAFE_0008, 0, "R7 copyback store hit");
    traffic(0, 0, 0, 0, "R7 no write");
    chk(peek(A + 8) == init_val(A + 8), "R7 memory untouched", peek(A + 8), init_val(A + 8));
    acc(0, CB, A + 8, 0, 0, "R7 read back");
    ctl(OP_UNLOCK, A, "R12 unlock dirty line");
    acc(0, CB, B, 0, 5, "R7 evict clean way");
    snap(); saw_br = 0; order_bad = 0;
    acc(0, CB, D, 0, 9, "R7 dirty miss");
    traffic(4, 4, 0, 0, "R7 write-back and refill");
    chk(order_bad == 0, "R7 write-back precedes refill", {31'b0, order_bad}, 32'h0);
    chk(peek(A + 8) == 32'hCAFE_0008, "R7 dirty word written back", peek(A + 8), 32'hCAFE_0008);
    chk(peek(A + 4) == init_val(A + 4), "R7 clean word written back", peek(A + 4), init_val(A + 4));

    snap(); acc(1, WT, B + 4, 32'h1234_5678, 1, "R8 writethrough hit");
    traffic(0, 0, 0, 1, "R8 single write");
    chk(peek(B + 4) == 32'h1234_5678, "R8 memory updated", peek(B + 4), 32'h1234_5678);
    snap(); acc(0, CB, B + 4, 0, 0, "R8 line updated"); traffic(0, 0, 0, 0, "R8 hit");

    snap(); acc(1, WT, E, 32'h0BAD_F00D, 1, "R9 writethrough miss");
    traffic(0, 0, 0, 1, "R9 single write");
    chk(peek(E) == 32'h0BAD_F00D, "R9 memory updated", peek(E), 32'h0BAD_F00D);
    snap(); acc(0, CB, E, 0, 5, "R9 not allocated"); traffic(4, 0, 0, 0, "R9 refill");

    snap(); acc(0, IN, F, 0, 1, "R10 inhibited load"); acc(0, IN3, F, 0, 1, "R10 inhibited load again");
    traffic(0, 0, 2, 0, "R10 single reads");
    snap(); acc(1, IN, F + 4, 32'h5555_AAAA, 1, "R10 inhibited store"); traffic(0, 0, 0, 1, "R10 single write");
    snap(); acc(0, CB, F + 4, 0, 5, "R10 not allocated"); traffic(4, 0, 0, 0, "R10 refill");
    snap(); acc(0, IN3, F + 4, 0, 1, "R10 bypass resident line"); traffic(0, 0, 1, 0, "R10 bypass");

    acc(1, CB, E + 4, 32'hDEAD_0004, 0, "R11 dirty the line");
    ctl(OP_INVAL, E, "R11 invalidate accepted");
    shadow_q[E + 4] = peek(E + 4);
    snap(); acc(0, CB, E + 4, 0, 5, "R11 line dropped"); traffic(4, 0, 0, 0, "R11 no write-back");
    ctl(OP_LOCK, E, "R11 lock before invalidate");
    ctl(OP_INVAL, E, "R11 invalidate locked line");
    acc(0, CB, 32'h0000_7080, 0, 5, "R11 fill after invalidate");
    acc(0, CB, 32'h0000_8080, 0, 5, "R11 fill other way");
    snap(); acc(0, CB, 32'h0000_7080, 0, 0, "R11 lock cleared"); traffic(0, 0, 0, 0, "R11 kept");

    repeat (4) @(posedge clk);
    chk(exp_q.size() == 0, "R2 all responses seen", 32'(exp_q.size()), 32'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule